// File: doc/BRIEF.md
# Vertical sub-band luma reconstruction filter

This block rebuilds full-height luminance from a stream that interleaves two vertical sub-bands: low-pass "main" lines and offset-coded high-pass "helper" lines. Each incoming pixel carries a tag that says which band it belongs to. The block normalises helper pixels by removing their mid-code. It then keeps each completed line in an on-chip ring of line buffers. For every new input pixel it produces one output pixel: a weighted sum of the co-sited samples of seven stored lines, rounded and clamped to the nominal luma range.

The weight row changes on every line and repeats over a four-line cycle. Camera and film material have separate sets of four rows. All rows are held in a small table that can be written at run time. A field-start pulse captures three settings for the whole field: interpolate, film, and which field of the frame is current. The mode and the field together set how many lines back the newest tap reaches. When interpolation is off, the block passes pixels through unchanged. A blank flag forces the black code in either mode.

Top module: `vsr_luma_recon`

## Requirements
- R1: After reset, out_valid is 0, pix_out is 16, the phase is 0, every stored sample is 0 and the block is in pass-through mode.
- R2: A pixel with pix_helper=1 is stored as its code minus 128. A pixel with pix_helper=0 is stored as its unsigned code.
- R3: In interpolate mode the output is S = sum over taps k=0..6 of C[film][phase][k] times the stored sample at age (D-1+k) in the same column. Age 0 is the most recently completed line. The output is floor((S+64)/128), clamped to 16..191.
- R4: An interpolated result below 16 is output as 16, and one above 191 is output as 191.
- R5: field_start resets the phase to 0. Each line_strobe advances it by one, modulo 4. The phase selects the coefficient row.
- R6: Writing with coef_we stores coef_data (9-bit two's complement, 7 fractional bits) at C[coef_film][coef_phase][coef_tap]. Camera rows (coef_film=0) and film rows (coef_film=1) are separate. Tap codes 7 and above are ignored. After reset, tap 0 of every row is 128 and all other taps are 0.
- R7: The delay D is 2 lines in film mode for the first field (second_field=0) and 3 lines for the second field. In camera mode it is 3 lines for the first field and 4 lines for the second.
- R8: When interpolation is off, pix_out equals pix_in of the same pixel, with no helper offset removed.
- R9: A pixel presented with blank_in=1 gives pix_out=16 in either mode. Its sample is still stored.
- R10: interp_en, film_mode and second_field take effect only at a field_start. Changes between field starts are ignored.
- R11: out_valid is high exactly one cycle after each cycle with pix_valid high. The result appears on pix_out in that cycle. line_strobe clears the column position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | Field-start pulse: captures the mode, clears phase and column |
| line_strobe | input | 1 | Line boundary: retires the current line, advances the phase |
| interp_en | input | 1 | 1 = interpolate, 0 = pass-through |
| film_mode | input | 1 | 1 = film coefficient set and delay, 0 = camera |
| second_field | input | 1 | 1 = second field of the frame |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 8 | Input pixel code |
| pix_helper | input | 1 | 1 = helper-band pixel (offset coded) |
| blank_in | input | 1 | Force the black code for this pixel |
| coef_we | input | 1 | Coefficient table write strobe |
| coef_film | input | 1 | Table half to write (0 camera, 1 film) |
| coef_phase | input | 2 | Phase row to write |
| coef_tap | input | 3 | Tap to write |
| coef_data | input | 9 | Signed coefficient, 7 fractional bits |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 8 | Output pixel code |

## Verification
The assertions check these rules on every cycle:
- the one-cycle valid latency;
- the black code on blanked pixels;
- pass-through equality when interpolation is off;
- the 16..191 bound on interpolated output;
- the phase reset and step;
- the mode settings holding steady between field starts.

Whether the sum picks the right lines, the right row and the right rounding can only be shown by the bench. It compares outputs against a reference sum built from its own copy of the line history. It sweeps all four mode and field cases, helper and main mixes, default and loaded tables, and saturating weights.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

    localparam int DATA_W     = 8;
    localparam int COEF_W     = 9;
    localparam int FRAC       = 7;
    localparam int TAPS       = 7;
    localparam int PHASES     = 4;
    localparam int MAX_DELAY  = 4;
    localparam int BLACK      = 16;
    localparam int WHITE      = 191;
    localparam int HELPER_MID = 128;

    localparam int TAP_W  = $clog2(TAPS);
    localparam int PH_W   = $clog2(PHASES);
    localparam int SAMP_W = DATA_W + 1;
    localparam int ACC_W  = SAMP_W + COEF_W + $clog2(TAPS);
    localparam int SLOTS  = MAX_DELAY - 1 + TAPS + 1;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int AGE_W  = $clog2(MAX_DELAY);

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic interp;
        logic film;
        logic second;
    } cfg_t;

    // newest tap age = delay - 1
    function automatic logic [AGE_W-1:0] base_age(input cfg_t c);
        int d;
        if (c.film) d = c.second ? 3 : 2;
        else        d = c.second ? 4 : 3;
        return AGE_W'(d - 1);
    endfunction

    function automatic samp_t normalise(input logic [DATA_W-1:0] p, input logic helper);
        samp_t s;
        s = samp_t'({1'b0, p});
        if (helper) s = s - samp_t'(HELPER_MID);
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] round_sat(input acc_t a);
        acc_t r;
        r = (a + acc_t'(1 << (FRAC - 1))) >>> FRAC;
        if (r < acc_t'(BLACK))      return DATA_W'(BLACK);
        else if (r > acc_t'(WHITE)) return DATA_W'(WHITE);
        else                        return DATA_W'(r);
    endfunction

endpackage

// File: rtl/vsr_coef_table.sv
module vsr_coef_table
    import vsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic                  wr_film,
    input  logic [PH_W-1:0]       wr_phase,
    input  logic [TAP_W-1:0]      wr_tap,
    input  coef_t                 wr_data,
    input  logic                  rd_film,
    input  logic [PH_W-1:0]       rd_phase,
    output coef_t [TAPS-1:0]      row
);
    localparam int ROWS = 2 * PHASES;

    coef_t tbl [ROWS][TAPS];

    logic [$clog2(ROWS)-1:0] wr_row, rd_row;
    assign wr_row = {wr_film, wr_phase};
    assign rd_row = {rd_film, rd_phase};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < TAPS; k++)
                    tbl[r][k] <= (k == 0) ? coef_t'(1 << FRAC) : '0;
        end else if (we && (int'(wr_tap) < TAPS)) begin
            tbl[wr_row][wr_tap] <= wr_data;
        end
    end

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_row
            assign row[k] = tbl[rd_row][k];
        end
    endgenerate

endmodule

// File: rtl/vsr_line_store.sv
module vsr_line_store
    import vsr_pkg::*;
#(
    parameter int LINE_W = 8,
    localparam int COL_W = $clog2(LINE_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [COL_W-1:0]      col,
    input  samp_t                 wr_data,
    input  logic                  advance,
    input  logic [AGE_W-1:0]      first_age,
    output samp_t [TAPS-1:0]      taps
);
    samp_t mem [SLOTS][LINE_W];
    logic [SLOT_W-1:0] wr_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot <= '0;
            for (int s = 0; s < SLOTS; s++)
                for (int c = 0; c < LINE_W; c++)
                    mem[s][c] <= '0;
        end else begin
            if (wr_en)
                mem[wr_slot][col] <= wr_data;
            if (advance)
                wr_slot <= (int'(wr_slot) == SLOTS - 1) ? '0 : wr_slot + 1'b1;
        end
    end

    // slot holding the line of age a: wr_slot - 1 - a, modulo SLOTS
    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            logic [SLOT_W-1:0] rd_slot;
            always_comb begin
                int s;
                s = int'(wr_slot) + SLOTS - 1 - int'(first_age) - k;
                if (s >= SLOTS) s = s - SLOTS;
                rd_slot = SLOT_W'(s);
            end
            assign taps[k] = mem[rd_slot][col];
        end
    endgenerate

endmodule

// File: rtl/vsr_mac.sv
module vsr_mac
    import vsr_pkg::*;
(
    input  samp_t [TAPS-1:0]      samples,
    input  coef_t [TAPS-1:0]      coefs,
    output logic [DATA_W-1:0]     result
);
    acc_t prod [TAPS];

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_prod
            acc_t s_ext, c_ext;
            assign s_ext   = acc_t'(samples[k]);
            assign c_ext   = acc_t'(coefs[k]);
            assign prod[k] = s_ext * c_ext;
        end
    endgenerate

    acc_t sum;
    always_comb begin
        sum = '0;
        for (int k = 0; k < TAPS; k++)
            sum = sum + prod[k];
    end

    assign result = round_sat(sum);

endmodule

// File: rtl/vsr_luma_recon.sv
module vsr_luma_recon
    import vsr_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  field_start,
    input  logic                  line_strobe,
    input  logic                  interp_en,
    input  logic                  film_mode,
    input  logic                  second_field,
    input  logic                  pix_valid,
    input  logic [7:0]            pix_in,
    input  logic                  pix_helper,
    input  logic                  blank_in,
    input  logic                  coef_we,
    input  logic                  coef_film,
    input  logic [1:0]            coef_phase,
    input  logic [2:0]            coef_tap,
    input  logic [8:0]            coef_data,
    output logic                  out_valid,
    output logic [7:0]            pix_out
);
    localparam int COL_W = $clog2(LINE_W);

    cfg_t               cfg_q;
    logic [PH_W-1:0]    phase_q;
    logic [COL_W-1:0]   col_q;
    logic               interp_act;
    logic [2:0]         cfg_bits;

    assign interp_act = cfg_q.interp;
    assign cfg_bits   = cfg_q;

    samp_t [TAPS-1:0]   taps;
    coef_t [TAPS-1:0]   row;
    logic [DATA_W-1:0]  filtered;

    vsr_coef_table i_table (
        .clk      (clk),
        .rst      (rst),
        .we       (coef_we),
        .wr_film  (coef_film),
        .wr_phase (coef_phase),
        .wr_tap   (coef_tap),
        .wr_data  (coef_t'(coef_data)),
        .rd_film  (cfg_q.film),
        .rd_phase (phase_q),
        .row      (row)
    );

    vsr_line_store #(.LINE_W(LINE_W)) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (pix_valid),
        .col       (col_q),
        .wr_data   (normalise(pix_in, pix_helper)),
        .advance   (line_strobe),
        .first_age (base_age(cfg_q)),
        .taps      (taps)
    );

    vsr_mac i_mac (
        .samples (taps),
        .coefs   (row),
        .result  (filtered)
    );

    // field / line / column sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            phase_q <= '0;
            col_q   <= '0;
        end else if (field_start) begin
            cfg_q   <= '{interp: interp_en, film: film_mode, second: second_field};
            phase_q <= '0;
            col_q   <= '0;
        end else if (line_strobe) begin
            phase_q <= phase_q + 1'b1;
            col_q   <= '0;
        end else if (pix_valid) begin
            col_q   <= (int'(col_q) == LINE_W - 1) ? '0 : col_q + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pix_out   <= DATA_W'(BLACK);
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) begin
                if (blank_in)          pix_out <= DATA_W'(BLACK);
                else if (cfg_q.interp) pix_out <= filtered;
                else                   pix_out <= pix_in;
            end
        end
    end

endmodule

// File: rtl/vsr_luma_recon_chk.sv
module vsr_luma_recon_chk
    import vsr_pkg::*;
#(
    parameter int LINE_W = 8,
    localparam int COL_W = $clog2(LINE_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              field_start,
    input logic              line_strobe,
    input logic              pix_valid,
    input logic [7:0]        pix_in,
    input logic              blank_in,
    input logic              out_valid,
    input logic [7:0]        pix_out,
    input logic              interp_act,
    input logic [2:0]        cfg_bits,
    input logic [PH_W-1:0]   phase,
    input logic [COL_W-1:0]  col
);
    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);
    // R11
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);
    // R11
    col_clear_chk: assert property (@(posedge clk) disable iff (rst)
        line_strobe |=> (col == '0));
    // R9
    blank_black_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && blank_in) |=> (pix_out == 8'(BLACK)));
    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !blank_in && !interp_act) |=> (pix_out == $past(pix_in)));
    // R4
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && interp_act) |=> (pix_out >= 8'(BLACK) && pix_out <= 8'(WHITE)));
    // R5
    phase_reset_chk: assert property (@(posedge clk) disable iff (rst)
        field_start |=> (phase == '0));
    // R5
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (line_strobe && !field_start) |=> (phase == PH_W'($past(phase) + 1)));
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(cfg_bits));
endmodule

bind vsr_luma_recon vsr_luma_recon_chk #(.LINE_W(LINE_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .field_start (field_start),
    .line_strobe (line_strobe),
    .pix_valid   (pix_valid),
    .pix_in      (pix_in),
    .blank_in    (blank_in),
    .out_valid   (out_valid),
    .pix_out     (pix_out),
    .interp_act  (interp_act),
    .cfg_bits    (cfg_bits),
    .phase       (phase_q),
    .col         (col_q)
);

// File: tb/test_vsr_luma_recon.sv
module test_vsr_luma_recon;
    localparam int LW = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       field_start = 0, line_strobe = 0;
    logic       interp_en = 0, film_mode = 0, second_field = 0;
    logic       pix_valid = 0, pix_helper = 0, blank_in = 0;
    logic [7:0] pix_in = '0;
    logic       coef_we = 0, coef_film = 0;
    logic [1:0] coef_phase = '0;
    logic [2:0] coef_tap = '0;
    logic [8:0] coef_data = '0;
    logic       out_valid;
    logic [7:0] pix_out;

    always #2 clk = ~clk;

    vsr_luma_recon #(.LINE_W(LW)) i_vsr_luma_recon (
        .clk(clk), .rst(rst), .field_start(field_start), .line_strobe(line_strobe),
        .interp_en(interp_en), .film_mode(film_mode), .second_field(second_field),
        .pix_valid(pix_valid), .pix_in(pix_in), .pix_helper(pix_helper), .blank_in(blank_in),
        .coef_we(coef_we), .coef_film(coef_film), .coef_phase(coef_phase),
        .coef_tap(coef_tap), .coef_data(coef_data),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int hist [12][LW];
    int coef_m [2][4][7];
    int ph = 0, col_m = 0;
    int m_interp = 0, m_film = 0, m_second = 0;

    task automatic check(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int norm(int v, bit h);
        return h ? v - 128 : v;
    endfunction

    function automatic int delay_of();
        if (m_film != 0) return (m_second != 0) ? 3 : 2;
        return (m_second != 0) ? 4 : 3;
    endfunction

    function automatic int ref_filter(int c);
        int acc, r, d;
        d = delay_of();
        acc = 0;
        for (int k = 0; k < 7; k++)
            acc += coef_m[m_film][ph][k] * hist[1 + d - 1 + k][c];
        r = (acc + 64) >>> 7;
        if (r < 16) r = 16;
        if (r > 191) r = 191;
        return r;
    endfunction

    task automatic send_pix(int v, bit h, bit b, string req);
        int exp;
        if (b) exp = 16;
        else if (m_interp != 0) exp = ref_filter(col_m);
        else exp = v;
        hist[0][col_m] = norm(v, h);
        @(negedge clk);
        pix_valid = 1; pix_in = 8'(v); pix_helper = h; blank_in = b;
        @(posedge clk); #1;
        check(int'(out_valid), 1, "R11 valid");
        check(int'(pix_out), exp, req);
        col_m = (col_m + 1) % LW;
    endtask

    task automatic strobe();
        @(negedge clk);
        pix_valid = 0; line_strobe = 1;
        @(posedge clk); #1;
        line_strobe = 0;
        check(int'(out_valid), 0, "R11 idle on strobe");
        for (int i = 11; i > 0; i--)
            for (int c = 0; c < LW; c++) hist[i][c] = hist[i-1][c];
        for (int c = 0; c < LW; c++) hist[0][c] = 0;
        ph = (ph + 1) % 4;
        col_m = 0;
    endtask

    task automatic fstart(int i, int f, int s);
        @(negedge clk);
        pix_valid = 0; field_start = 1;
        interp_en = i[0]; film_mode = f[0]; second_field = s[0];
        @(posedge clk); #1;
        field_start = 0;
        m_interp = i; m_film = f; m_second = s;
        ph = 0; col_m = 0;
    endtask

    task automatic load_coef(int f, int p, int k, int val);
        @(negedge clk);
        coef_we = 1; coef_film = f[0]; coef_phase = 2'(p); coef_tap = 3'(k);
        coef_data = 9'(val);
        @(posedge clk); #1;
        coef_we = 0;
        if (k < 7) coef_m[f][p][k] = val;
    endtask

    // kind 0: varied pattern, 1: unit tap 0, 2: large tap 0
    task automatic load_table(int kind);
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 7; k++) begin
                    int v;
                    if (kind == 0) v = ((f*37 + p*13 + k*29 + 11) % 97) - 40;
                    else if (kind == 1) v = (k == 0) ? 128 : 0;
                    else v = (k == 0) ? 255 : 0;
                    load_coef(f, p, k, v);
                end
    endtask

    // helper_mode 0: all main, 1: odd lines helper
    task automatic run_lines(int n, int seed, int helper_mode, string req);
        for (int ln = 0; ln < n; ln++) begin
            for (int c = 0; c < LW; c++) begin
                int v; bit h, b;
                v = (seed + ln*71 + c*53 + ln*c*7) % 256;
                h = (helper_mode == 1) && (ln % 2 == 1);
                b = (c == ln % LW) && (ln % 3 == 0);
                send_pix(v, h, b, b ? "R9 blank" : req);
            end
            strobe();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++)
            for (int c = 0; c < LW; c++) hist[i][c] = 0;
        for (int f = 0; f < 2; f++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 7; k++) coef_m[f][p][k] = (k == 0) ? 128 : 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check(int'(out_valid), 0, "R1 out_valid");
        check(int'(pix_out), 16, "R1 pix_out");

        // default table, starting from cleared history
        fstart(1, 0, 0);
        run_lines(6, 5, 0, "R6 default table");

        // loaded table over all mode and field cases
        load_coef(0, 0, 7, 99);   // tap code 7 is ignored (R6)
        load_table(0);
        fstart(1, 0, 0); run_lines(12, 17, 1, "R3 R7 camera first");
        fstart(1, 0, 1); run_lines(12, 40, 1, "R3 R7 camera second");
        fstart(1, 1, 0); run_lines(12, 91, 1, "R3 R7 film first");
        fstart(1, 1, 1); run_lines(12, 133, 1, "R3 R7 film second");

        // helper offset
        load_table(1);
        fstart(1, 1, 0); run_lines(8, 200, 1, "R2 helper offset");

        // saturation both ways
        load_table(2);
        fstart(1, 0, 1); run_lines(8, 77, 1, "R4 saturation");

        // pass-through
        fstart(0, 0, 0); run_lines(5, 3, 1, "R8 bypass");
        fstart(0, 1, 1); run_lines(3, 9, 1, "R8 bypass film");

        // mode inputs ignored between field starts
        load_table(0);
        fstart(1, 0, 0);
        @(negedge clk); interp_en = 0; film_mode = 1; second_field = 1;
        run_lines(6, 61, 1, "R10 held config");

        // phase reset mid-sequence
        fstart(1, 1, 1);
        run_lines(2, 150, 0, "R5 before reset");
        fstart(1, 1, 1);
        run_lines(5, 170, 1, "R5 after reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule